// File: doc/BRIEF.md
# Packed dual-halfword saturating shifter

This block shifts a 32-bit word that holds two signed 16-bit lanes. Both lanes take the same shift amount and the same direction. Each lane is handled on its own. A left shift is arithmetic and saturating: a lane whose shifted value no longer fits in 16 signed bits is clamped to the largest positive or most negative 16-bit value. A right shift is arithmetic and copies each lane's sign into the vacated high bits.

For every lane, a flag reports whether that lane was clamped. An output register can be switched in by parameter. With the default setting, the result appears one cycle after an input marked valid, and a valid output follows it. The block is meant to sit in a packed-arithmetic datapath, where the shift amount comes from an instruction immediate.

Top module: `dual_lane_shifter`

## Requirements
- R1: The upper lane is bits 31:16 and the lower lane is bits 15:0. Each lane's result depends only on that lane's input bits, so nothing crosses from one lane into the other.
- R2: On a left shift (dir_right = 0), a lane whose exact product value × 2^shamt is above 32767 becomes 0x7FFF. A lane whose product is below −32768 becomes 0x8000.
- R3: A shift amount of 0 returns the operand unchanged in both directions, with no lane flagged.
- R4: On a right shift (dir_right = 1), each lane equals floor(value / 2^shamt), so the vacated bits are filled with that lane's own sign bit.
- R5: A right shift by 15 gives 0x0000 for a non-negative lane and 0xFFFF for a negative lane.
- R6: A left shift that fits in 16 signed bits returns the exact value, with zeros in the vacated low bits. This includes a result of exactly −32768.
- R7: lane_sat[1] belongs to the upper lane and lane_sat[0] to the lower lane. A bit is 1 exactly when that lane was clamped by a left shift. A right shift never sets a bit.
- R8: An input accepted with in_valid = 1 appears on result and lane_sat one cycle later, with out_valid = 1. out_valid is the input in_valid delayed by one cycle. A synchronous reset clears out_valid, result and lane_sat to 0.
- R9: In a cycle with in_valid = 0, result and lane_sat keep their previous values, whatever the operand, direction and shift amount are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operand, direction and amount are valid this cycle |
| operand | input | 32 | Two packed signed 16-bit lanes |
| dir_right | input | 1 | 0 = saturating left shift, 1 = arithmetic right shift |
| shamt | input | 4 | Shift amount, 0 to 15 |
| out_valid | output | 1 | result and lane_sat hold a new value |
| result | output | 32 | Shifted lanes, each in place |
| lane_sat | output | 2 | Per-lane clamp flags for a left shift |

## Verification
The hardest case to reach is the edge of the left-shift range. A product of exactly −32768 must pass through unclamped, while a product of +32768 must clamp. Random operands almost never land on these values. Directed vectors therefore build them from 0x4000/0xC000 shifted by 1 and from 0x0001/0xFFFF shifted by 15. Other directed vectors put a clamping lane next to an exact lane, to show that the two lanes decide independently. Random vectors are then compared against an integer reference model lane by lane.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/dls_lane.sv
module dls_lane #(
    parameter int LANE_W  = 16,
    parameter int SHAMT_W = 4
) (
    input  logic [LANE_W-1:0]  lane_in,
    input  logic               dir_right,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [LANE_W-1:0]  lane_out,
    output logic               lane_sat
);
    import dls_pkg::*;

    localparam int WIDE_W = 2 * LANE_W;

    logic              sign_bit;
    logic [WIDE_W-1:0] ext_val;
    logic [WIDE_W-1:0] wide_shl;
    logic              lost_bits;
    logic [LANE_W-1:0] clamp_val;

    always_comb begin
        sign_bit  = lane_in[LANE_W-1];
        ext_val   = {{LANE_W{sign_bit}}, lane_in};
        wide_shl  = ext_val << shamt;
        // bits pushed out plus new sign must all repeat the old sign
        lost_bits = (wide_shl[WIDE_W-1:LANE_W-1] != {(LANE_W+1){sign_bit}});
        clamp_val = sign_bit ? {1'b1, {(LANE_W-1){1'b0}}}
                             : {1'b0, {(LANE_W-1){1'b1}}};
        if (shift_dir_e'(dir_right) == DIR_RIGHT) begin
            lane_out = LANE_W'($signed(lane_in) >>> shamt);
            lane_sat = 1'b0;
        end else if (lost_bits) begin
            lane_out = clamp_val;
            lane_sat = 1'b1;
        end else begin
            lane_out = wide_shl[LANE_W-1:0];
            lane_sat = 1'b0;
        end
    end

endmodule

// File: rtl/dls_outreg.sv
module dls_outreg #(
    parameter int WORD_W     = 32,
    parameter int LANES      = 2,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] res_in,
    input  logic [LANES-1:0]  sat_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_out,
    output logic [LANES-1:0]  sat_out
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        logic [LANES-1:0]  sat;
    } stage_t;

    generate
        if (REGISTERED) begin : g_reg
            stage_t stage_d, stage_q;

            always_comb begin
                stage_d     = stage_q;
                stage_d.vld = in_valid;
                if (in_valid) begin
                    stage_d.res = res_in;
                    stage_d.sat = sat_in;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= stage_d;
            end

            assign out_valid = stage_q.vld;
            assign res_out   = stage_q.res;
            assign sat_out   = stage_q.sat;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign res_out   = res_in;
            assign sat_out   = sat_in;
        end
    endgenerate

endmodule

// File: rtl/dual_lane_shifter.sv
module dual_lane_shifter #(
    parameter int LANE_W     = 16,
    parameter int LANES      = 2,
    parameter bit REGISTERED = 1'b1,
    localparam int SHAMT_W   = $clog2(LANE_W),
    localparam int WORD_W    = LANE_W * LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  operand,
    input  logic               dir_right,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [WORD_W-1:0]  result,
    output logic [LANES-1:0]   lane_sat
);
    logic [WORD_W-1:0] comb_res;
    logic [LANES-1:0]  comb_sat;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            dls_lane #(
                .LANE_W (LANE_W),
                .SHAMT_W(SHAMT_W)
            ) u_lane (
                .lane_in  (operand[i*LANE_W +: LANE_W]),
                .dir_right(dir_right),
                .shamt    (shamt),
                .lane_out (comb_res[i*LANE_W +: LANE_W]),
                .lane_sat (comb_sat[i])
            );
        end
    endgenerate

    dls_outreg #(
        .WORD_W    (WORD_W),
        .LANES     (LANES),
        .REGISTERED(REGISTERED)
    ) u_outreg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .res_in   (comb_res),
        .sat_in   (comb_sat),
        .out_valid(out_valid),
        .res_out  (result),
        .sat_out  (lane_sat)
    );

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int LANE_W     = 16,
    parameter int LANES      = 2,
    parameter bit REGISTERED = 1'b1,
    localparam int SHAMT_W   = $clog2(LANE_W),
    localparam int WORD_W    = LANE_W * LANES
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [WORD_W-1:0]  operand,
    input logic               dir_right,
    input logic [SHAMT_W-1:0] shamt,
    input logic               out_valid,
    input logic [WORD_W-1:0]  result,
    input logic [LANES-1:0]   lane_sat
);
    localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    generate
        if (REGISTERED) begin : g_chk
            // R8
            valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            // R8
            valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R9
            hold_result_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(result) && $stable(lane_sat)));
            // R7
            right_no_sat_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && dir_right) |=> (lane_sat == '0));
            // R3
            zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && shamt == '0) |=> (result == $past(operand) && lane_sat == '0));
            for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
                // R2
                clamp_value_chk: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && lane_sat[i]) |->
                    (result[i*LANE_W +: LANE_W] == POS_MAX || result[i*LANE_W +: LANE_W] == NEG_MIN));
            end
        end
    endgenerate

endmodule

bind dual_lane_shifter dls_checker #(
    .LANE_W    (LANE_W),
    .LANES     (LANES),
    .REGISTERED(REGISTERED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .operand  (operand),
    .dir_right(dir_right),
    .shamt    (shamt),
    .out_valid(out_valid),
    .result   (result),
    .lane_sat (lane_sat)
);

// File: tb/dual_lane_shifter_tb.sv
module dual_lane_shifter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] operand;
    logic        dir_right;
    logic [3:0]  shamt;
    logic        out_valid;
    logic [31:0] result;
    logic [1:0]  lane_sat;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_lane_shifter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .dir_right(dir_right), .shamt(shamt), .out_valid(out_valid),
        .result(result), .lane_sat(lane_sat)
    );

    // {operand, dir_right, shamt, expected result, expected lane_sat}
    localparam int NVEC = 12;
    localparam logic [70:0] VECS [NVEC] = '{
        {32'h01230ABC, 1'b0, 4'd0,  32'h01230ABC, 2'b00},
        {32'h12345678, 1'b0, 4'd3,  32'h7FFF7FFF, 2'b11},
        {32'h456789AB, 1'b0, 4'd9,  32'h7FFF8000, 2'b11},
        {32'h789ABCDE, 1'b0, 4'd13, 32'h7FFF8000, 2'b11},
        {32'h456789AB, 1'b1, 4'd11, 32'h0008FFF1, 2'b00},
        {32'h3456789A, 1'b1, 4'd15, 32'h00000000, 2'b00},
        {32'h12345678, 1'b1, 4'd8,  32'h00120056, 2'b00},
        {32'h0001FFFF, 1'b0, 4'd3,  32'h0008FFF8, 2'b00},
        {32'h4000C000, 1'b0, 4'd1,  32'h7FFF8000, 2'b10},
        {32'h80007FFF, 1'b1, 4'd15, 32'hFFFF0000, 2'b00},
        {32'h00030001, 1'b0, 4'd14, 32'h7FFF4000, 2'b10},
        {32'hFFFF0001, 1'b0, 4'd15, 32'h80007FFF, 2'b01}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R3";
            1, 2, 3: return "R2";
            4, 6:    return "R4";
            5, 9:    return "R5";
            7:       return "R6";
            8, 11:   return "R6/R2 boundary";
            default: return "R1 mixed lanes";
        endcase
    endfunction

    // integer reference: returns {sat, lane}
    function automatic logic [16:0] ref_lane(logic [15:0] v, logic d, logic [3:0] s);
        int iv;
        int p;
        iv = int'($signed(v));
        if (d) begin
            p = iv >>> s;
            return {1'b0, p[15:0]};
        end
        p = iv * (1 << s);
        if (p > 32767)  return {1'b1, 16'h7FFF};
        if (p < -32768) return {1'b1, 16'h8000};
        return {1'b0, p[15:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] op, logic d, logic [3:0] s);
        @(negedge clk);
        in_valid  = 1'b1;
        operand   = op;
        dir_right = d;
        shamt     = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; operand = 32'hA5A5_5A5A; dir_right = 1'b0; shamt = 4'd7;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset result",    result,             32'd0);
        check("R8 reset lane_sat",  {30'd0, lane_sat},  32'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][70:39], VECS[i][38], VECS[i][37:34]);
            check({vec_tag(i), " result"},   result,            VECS[i][33:2]);
            check({"R7 ", vec_tag(i), " sat"}, {30'd0, lane_sat}, {30'd0, VECS[i][1:0]});
            check("R8 out_valid",             {31'd0, out_valid}, 32'd1);
        end

        // R8 latency from idle, R9 hold while invalid
        @(negedge clk);
        in_valid = 1'b0; operand = 32'h1111_2222;
        @(negedge clk);
        check("R8 out_valid drops", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b1; operand = 32'h0001_0002; dir_right = 1'b0; shamt = 4'd2;
        #1;
        check("R8 no early output", result, 32'h80007FFF);
        @(negedge clk);
        check("R8 one cycle latency", result, 32'h0004_0008);
        check("R8 out_valid rises", {31'd0, out_valid}, 32'd1);
        in_valid = 1'b0; operand = 32'h7FFF_7FFF; shamt = 4'd15;
        @(negedge clk);
        check("R9 result held", result, 32'h0004_0008);
        check("R9 lane_sat held", {30'd0, lane_sat}, 32'd0);
        dir_right = 1'b1; operand = 32'h8000_8000;
        @(negedge clk);
        check("R9 result still held", result, 32'h0004_0008);

        // R1 random lanes against reference model
        for (int n = 0; n < 300; n++) begin
            logic [31:0] op;
            logic        d;
            logic [3:0]  s;
            logic [16:0] hi, lo;
            op = $urandom;
            d  = 1'($urandom);
            s  = 4'($urandom);
            hi = ref_lane(op[31:16], d, s);
            lo = ref_lane(op[15:0], d, s);
            apply(op, d, s);
            check("R1 random result", result, {hi[15:0], lo[15:0]});
            check("R7 random sat", {30'd0, lane_sat}, {30'd0, hi[16], lo[16]});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule